// File: doc/BRIEF.md
# Wide-to-Narrow Bus Byte Bridge

This block sits between a 16-bit host bus that marks the bytes it uses with an upper and a lower data strobe, and an 8-bit peripheral bus. The host has no address bit 0. Its strobes tell which byte or bytes of the addressed 16-bit word it wants. The bridge turns every host cycle into one or two byte transfers on the narrow side. It moves each byte between the narrow data lines and the correct half of the wide data bus. It holds back the host acknowledge until the last byte transfer has finished.

The narrow address is the host word address with one extra low bit added. That bit is 0 for the byte selected by the upper strobe and 1 for the byte selected by the lower strobe. A write of a single byte from the host shows that byte on both halves of the wide bus, so the bridge takes it from the half that the active strobe names. Reads always return a full 16-bit value. The host keeps the half it needs. A half whose strobe was not active reads as all ones.

All strobes, requests, ready and acknowledge signals are active high. The host keeps its address, strobes, direction and write data steady until it sees the acknowledge. A host that lets both strobes fall before the acknowledge abandons its cycle.

Top module: `wnb_bridge`

## Requirements
- R1: With only the upper strobe active, exactly one narrow transfer is made at narrow address {host address, 0}. A read returns the byte on h_rdata[15:8] and 0xFF on h_rdata[7:0].
- R2: With only the lower strobe active, exactly one narrow transfer is made at narrow address {host address, 1}. A read returns the byte on h_rdata[7:0] and 0xFF on h_rdata[15:8].
- R3: With both strobes active, two narrow transfers are made, the even address first and then the odd one. Both complete before the single acknowledge, and a read returns the even byte on [15:8] and the odd byte on [7:0].
- R4: On a write, the byte sent to the even address is h_wdata[15:8] and the byte sent to the odd address is h_wdata[7:0]. n_we is 1 for writes and 0 for reads.
- R5: While n_req is high and n_rdy is low, n_req stays high and n_addr, n_wdata and n_we do not change. A transfer completes on a clock edge where n_req and n_rdy are both high.
- R6: h_ack is high for exactly one clock cycle per completed host cycle, in the cycle after the last transfer completes. h_rdata holds the read result during that cycle.
- R7: If the host drops both strobes before the acknowledge, a narrow transfer already requested is still completed. No further transfer is started and no acknowledge is given.
- R8: After an acknowledge, the bridge starts no new narrow transfer until both strobes have been seen low.
- R9: After reset, n_req and h_ack are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_addr | input | HOST_AW | Host word address (no bit 0) |
| h_ustb | input | 1 | Upper data strobe, selects bits 15..8 and the even byte |
| h_lstb | input | 1 | Lower data strobe, selects bits 7..0 and the odd byte |
| h_rd | input | 1 | 1 for a read cycle, 0 for a write cycle |
| h_wdata | input | 2*BYTE_W | Host write data |
| h_rdata | output | 2*BYTE_W | Host read data |
| h_ack | output | 1 | One-cycle cycle-complete pulse |
| n_addr | output | HOST_AW+1 | Narrow byte address |
| n_wdata | output | BYTE_W | Narrow write byte |
| n_rdata | input | BYTE_W | Narrow read byte, taken when n_rdy is high |
| n_we | output | 1 | Narrow transfer is a write |
| n_req | output | 1 | Narrow transfer request |
| n_rdy | input | 1 | Narrow transfer complete |

## Verification
The bench builds the bridge with HOST_AW = 10 and the default byte width of 8. This makes the narrow address only 11 bits wide, so a word access at the top word address can reach byte address 0x7FF, and the added low bit is easy to see against the base. The peripheral model's ready latency is changed between cycles, from zero wait states up to several. This covers back-to-back completions, the case where the request holds steady for a long time, and an abandoned word cycle whose first byte is still in flight.

// File: rtl/wnb_pkg.sv
`timescale 1ns/1ps
package wnb_pkg;
  // Byte lanes of the wide bus; lane 0 is the upper half / even address.
  localparam int unsigned LANES  = 2;
  localparam int unsigned LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_XFER,
    SEQ_ACK,
    SEQ_HOLD
  } seq_state_e;

  // First lane to serve: even byte when the upper strobe is active.
  function automatic logic [LANE_W-1:0] lead_lane(input logic up, input logic lo);
    return (up || !lo) ? '0 : LANE_W'(1);
  endfunction

  // A second transfer follows only when both strobes are active.
  function automatic logic needs_second(input logic up, input logic lo);
    return up && lo;
  endfunction
endpackage

// File: rtl/wnb_lane_plan.sv
`timescale 1ns/1ps
module wnb_lane_plan
  import wnb_pkg::*;
(
  input  logic              up_stb,
  input  logic              lo_stb,
  output logic              any_stb,
  output logic [LANE_W-1:0] first_lane,
  output logic              two_lanes
);
  always_comb begin
    any_stb    = up_stb | lo_stb;
    first_lane = lead_lane(up_stb, lo_stb);
    two_lanes  = needs_second(up_stb, lo_stb);
  end
endmodule

// File: rtl/wnb_sequencer.sv
`timescale 1ns/1ps
module wnb_sequencer
  import wnb_pkg::*;
#(
  parameter int unsigned BASE_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BASE_W-1:0] h_addr,
  input  logic              h_ustb,
  input  logic              h_lstb,
  input  logic              h_rd,
  input  logic              n_rdy,
  output logic              n_req,
  output logic              n_we,
  output logic [LANE_W-1:0] cur_lane,
  output logic [BASE_W-1:0] cur_base,
  output logic [LANES-1:0]  lane_used,
  output logic              h_ack,
  output logic              start_evt,
  output logic              xfer_done,
  output logic              is_read
);
  seq_state_e        state_q;
  logic [LANE_W-1:0] lane_q;
  logic [BASE_W-1:0] base_q;
  logic              rd_q;
  logic              second_q;
  logic              abort_q;
  logic [LANES-1:0]  used_q;

  logic              any_stb;
  logic [LANE_W-1:0] first_lane;
  logic              two_lanes;
  logic              abort_now;
  logic              advance_evt;

  wnb_lane_plan u_plan (
    .up_stb     (h_ustb),
    .lo_stb     (h_lstb),
    .any_stb    (any_stb),
    .first_lane (first_lane),
    .two_lanes  (two_lanes)
  );

  always_comb begin
    start_evt   = (state_q == SEQ_IDLE) && any_stb;
    xfer_done   = (state_q == SEQ_XFER) && n_rdy;
    abort_now   = abort_q || !any_stb;
    advance_evt = xfer_done && !abort_now && second_q;
    n_req       = (state_q == SEQ_XFER);
    n_we        = !rd_q;
    h_ack       = (state_q == SEQ_ACK);
    cur_lane    = lane_q;
    cur_base    = base_q;
    lane_used   = used_q;
    is_read     = rd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      lane_q   <= '0;
      base_q   <= '0;
      rd_q     <= 1'b1;
      second_q <= 1'b0;
      abort_q  <= 1'b0;
      used_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (any_stb) begin
            base_q   <= h_addr;
            rd_q     <= h_rd;
            lane_q   <= first_lane;
            second_q <= two_lanes;
            used_q   <= {h_ustb, h_lstb};
            abort_q  <= 1'b0;
            state_q  <= SEQ_XFER;
          end
        end
        SEQ_XFER: begin
          if (!any_stb) abort_q <= 1'b1;
          if (n_rdy) begin
            if (abort_now) begin
              state_q <= SEQ_HOLD;
            end else if (second_q) begin
              lane_q   <= lane_q + LANE_W'(1);
              second_q <= 1'b0;
            end else begin
              state_q <= SEQ_ACK;
            end
          end
        end
        SEQ_ACK:  state_q <= SEQ_HOLD;
        SEQ_HOLD: if (!any_stb) state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  // R9
  reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> !n_req && !h_ack);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_req && !n_rdy |=> n_req && $stable(lane_q) && $stable(base_q) && $stable(n_we));

  // R3
  odd_follows_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    advance_evt |=> n_req && (cur_lane == LANE_W'(1)) && !h_ack);

  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_ack |=> !h_ack && !n_req);

  // R7
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && abort_now |=> !h_ack && !n_req);

  // R8
  hold_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_HOLD) && any_stb |=> !n_req);
endmodule

// File: rtl/wnb_write_steer.sv
`timescale 1ns/1ps
module wnb_write_steer
  import wnb_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_evt,
  input  logic [LANES*BYTE_W-1:0] h_wdata,
  input  logic [LANE_W-1:0]       lane,
  output logic [BYTE_W-1:0]       n_wdata
);
  logic [LANES*BYTE_W-1:0] word_q;
  logic [BYTE_W-1:0]       slice [LANES];

  always_ff @(posedge clk) begin
    if (!rst_n)         word_q <= '0;
    else if (start_evt) word_q <= h_wdata;
  end

  // Lane 0 is the most significant byte of the wide word.
  for (genvar g = 0; g < LANES; g++) begin : g_slice
    assign slice[g] = word_q[(LANES-1-g)*BYTE_W +: BYTE_W];
  end

  assign n_wdata = slice[lane];
endmodule

// File: rtl/wnb_read_merge.sv
`timescale 1ns/1ps
module wnb_read_merge
  import wnb_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_evt,
  input  logic                    xfer_done,
  input  logic                    is_read,
  input  logic [LANE_W-1:0]       lane,
  input  logic [BYTE_W-1:0]       n_rdata,
  output logic [LANES*BYTE_W-1:0] h_rdata
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        byte_q <= '1;
      else if (start_evt)
        byte_q <= '1;
      else if (xfer_done && is_read && (lane == LANE_W'(g)))
        byte_q <= n_rdata;
    end
    assign h_rdata[(LANES-1-g)*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/wnb_bridge.sv
`timescale 1ns/1ps
module wnb_bridge
  import wnb_pkg::*;
#(
  parameter int unsigned HOST_AW = 23,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [HOST_AW-1:0]        h_addr,
  input  logic                      h_ustb,
  input  logic                      h_lstb,
  input  logic                      h_rd,
  input  logic [2*BYTE_W-1:0]       h_wdata,
  output logic [2*BYTE_W-1:0]       h_rdata,
  output logic                      h_ack,
  output logic [HOST_AW+LANE_W-1:0] n_addr,
  output logic [BYTE_W-1:0]         n_wdata,
  input  logic [BYTE_W-1:0]         n_rdata,
  output logic                      n_we,
  output logic                      n_req,
  input  logic                      n_rdy
);
  logic [LANE_W-1:0]  cur_lane;
  logic [HOST_AW-1:0] cur_base;
  logic [LANES-1:0]   lane_used;
  logic               start_evt;
  logic               xfer_done;
  logic               is_read;

  wnb_sequencer #(.BASE_W(HOST_AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_addr    (h_addr),
    .h_ustb    (h_ustb),
    .h_lstb    (h_lstb),
    .h_rd      (h_rd),
    .n_rdy     (n_rdy),
    .n_req     (n_req),
    .n_we      (n_we),
    .cur_lane  (cur_lane),
    .cur_base  (cur_base),
    .lane_used (lane_used),
    .h_ack     (h_ack),
    .start_evt (start_evt),
    .xfer_done (xfer_done),
    .is_read   (is_read)
  );

  wnb_write_steer #(.BYTE_W(BYTE_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .h_wdata   (h_wdata),
    .lane      (cur_lane),
    .n_wdata   (n_wdata)
  );

  wnb_read_merge #(.BYTE_W(BYTE_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_evt (start_evt),
    .xfer_done (xfer_done),
    .is_read   (is_read),
    .lane      (cur_lane),
    .n_rdata   (n_rdata),
    .h_rdata   (h_rdata)
  );

  // The strobe-derived lane becomes the missing low address bit.
  assign n_addr = {cur_base, cur_lane};

  // R1
  upper_only_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_ack && is_read && !lane_used[0] |-> h_rdata[BYTE_W-1:0] == '1);

  // R2
  lower_only_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_ack && is_read && !lane_used[1] |-> h_rdata[2*BYTE_W-1:BYTE_W] == '1);

  // R5
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_req && !n_rdy |=> $stable(n_wdata) && $stable(n_addr));
endmodule

// File: tb/wnb_bridge_bench.sv
`timescale 1ns/1ps
module wnb_bridge_bench;
  localparam int unsigned AW = 10;
  localparam int unsigned BW = 8;
  localparam int unsigned NAW = AW + 1;

  typedef struct packed {
    logic           we;
    logic [NAW-1:0] addr;
    logic [BW-1:0]  data;
  } xfer_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0]   h_addr = '0;
  logic            h_ustb = 1'b0, h_lstb = 1'b0, h_rd = 1'b1;
  logic [2*BW-1:0] h_wdata = '0;
  logic [2*BW-1:0] h_rdata;
  logic            h_ack;
  logic [NAW-1:0]  n_addr;
  logic [BW-1:0]   n_wdata;
  logic [BW-1:0]   n_rdata = '0;
  logic            n_we, n_req;
  logic            n_rdy = 1'b0;

  int checks = 0;
  int fails = 0;
  int lat = 0;
  bit done = 1'b0;
  xfer_t expq[$];

  always #2.5 clk = ~clk;

  wnb_bridge #(.HOST_AW(AW), .BYTE_W(BW)) u_wnb_bridge (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_ustb(h_ustb), .h_lstb(h_lstb),
    .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ack(h_ack),
    .n_addr(n_addr), .n_wdata(n_wdata), .n_rdata(n_rdata), .n_we(n_we),
    .n_req(n_req), .n_rdy(n_rdy)
  );

  // Peripheral contents: a fixed mixing of the byte address.
  function automatic logic [BW-1:0] mem_byte(input logic [NAW-1:0] a);
    return BW'(a * 7) ^ 8'h3C ^ BW'(a >> 8);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor / peripheral model: pops expected transfers as they complete.
  initial begin
    int cnt = 0;
    logic was_wait = 1'b0;
    logic [NAW-1:0] p_addr = '0;
    logic [BW-1:0]  p_data = '0;
    logic           p_we = 1'b0;
    forever begin
      @(negedge clk);
      n_rdy = 1'b0;
      if (n_req && was_wait) begin
        // R5: request fields stay put while waiting
        check("R5 addr stable", 32'(n_addr), 32'(p_addr));
        check("R5 data stable", 32'(n_wdata), 32'(p_data));
        check("R5 we stable", 32'(n_we), 32'(p_we));
      end
      was_wait = 1'b0;
      if (n_req) begin
        if (cnt >= lat) begin
          xfer_t e;
          n_rdy = 1'b1;
          n_rdata = mem_byte(n_addr);
          cnt = 0;
          checks++;
          if (expq.size() == 0) begin
            fails++;
            $display("FAIL R7/R8 unexpected transfer actual=%0h expected=none", n_addr);
          end else begin
            e = expq.pop_front();
            check("R1/R2/R3 narrow addr", 32'(n_addr), 32'(e.addr));
            check("R4 we", 32'(n_we), 32'(e.we));
            if (e.we) check("R4 write byte", 32'(n_wdata), 32'(e.data));
          end
        end else begin
          cnt++;
          was_wait = 1'b1;
          p_addr = n_addr; p_data = n_wdata; p_we = n_we;
        end
      end else begin
        cnt = 0;
      end
    end
  end

  task automatic host_cycle(input string req, input logic [AW-1:0] a, input logic u,
                            input logic l, input logic rd, input logic [2*BW-1:0] wd,
                            input int wait_lat, input int hold_extra);
    xfer_t e;
    logic [2*BW-1:0] exp_rd;
    bit got = 1'b0;
    lat = wait_lat;
    exp_rd = '1;
    if (u) begin
      e.we = !rd; e.addr = {a, 1'b0}; e.data = wd[2*BW-1:BW];
      expq.push_back(e);
      exp_rd[2*BW-1:BW] = mem_byte({a, 1'b0});
    end
    if (l) begin
      e.we = !rd; e.addr = {a, 1'b1}; e.data = wd[BW-1:0];
      expq.push_back(e);
      exp_rd[BW-1:0] = mem_byte({a, 1'b1});
    end
    @(negedge clk);
    h_addr = a; h_ustb = u; h_lstb = l; h_rd = rd; h_wdata = wd;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (h_ack) begin got = 1'b1; break; end
    end
    check({req, " ack seen"}, 32'(got), 32'd1);
    // R3: every byte transfer finished before the acknowledge
    check({req, " all transfers before ack"}, 32'(expq.size()), 32'd0);
    if (rd) check({req, " read data"}, 32'(h_rdata), 32'(exp_rd));
    for (int i = 0; i < hold_extra; i++) begin
      @(negedge clk);
      check("R6/R8 no repeat ack", 32'(h_ack), 32'd0);
    end
    @(negedge clk);
    check("R6 ack one cycle", 32'(h_ack), 32'd0);
    h_ustb = 1'b0; h_lstb = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: quiet outputs under and after reset
    check("R9 n_req in reset", 32'(n_req), 32'd0);
    check("R9 h_ack in reset", 32'(h_ack), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 n_req after reset", 32'(n_req), 32'd0);
    check("R9 h_ack after reset", 32'(h_ack), 32'd0);

    host_cycle("R1 upper read", 10'h012, 1'b1, 1'b0, 1'b1, '0, 0, 0);
    host_cycle("R2 lower read", 10'h155, 1'b0, 1'b1, 1'b1, '0, 2, 0);
    host_cycle("R3 word read", 10'h0A3, 1'b1, 1'b1, 1'b1, '0, 1, 0);
    host_cycle("R4 upper write", 10'h021, 1'b1, 1'b0, 1'b0, 16'hC35A, 0, 0);
    host_cycle("R4 lower write", 10'h022, 1'b0, 1'b1, 1'b0, 16'hC35A, 1, 0);
    host_cycle("R4 word write", 10'h200, 1'b1, 1'b1, 1'b0, 16'hBEEF, 3, 0);
    host_cycle("R4 dup byte write", 10'h033, 1'b0, 1'b1, 1'b0, 16'h1212, 0, 0);
    host_cycle("R3 top address", 10'h3FF, 1'b1, 1'b1, 1'b1, '0, 0, 0);
    // R8: strobes held after ack start nothing new
    host_cycle("R8 held strobes", 10'h0F0, 1'b1, 1'b1, 1'b1, '0, 2, 4);
    host_cycle("R5 long wait", 10'h111, 1'b1, 1'b1, 1'b0, 16'h7E81, 5, 0);

    begin : abort_case
      // R7: word read dropped while the even byte is in flight
      xfer_t e;
      bit acked = 1'b0;
      lat = 4;
      e.we = 1'b0; e.addr = {10'h2C4, 1'b0}; e.data = '0;
      expq.push_back(e);
      @(negedge clk);
      h_addr = 10'h2C4; h_rd = 1'b1; h_ustb = 1'b1; h_lstb = 1'b1;
      repeat (2) @(negedge clk);
      h_ustb = 1'b0; h_lstb = 1'b0;
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        if (h_ack) acked = 1'b1;
      end
      check("R7 no ack after abort", 32'(acked), 32'd0);
      check("R7 in-flight byte finished", 32'(expq.size()), 32'd0);
      check("R7 bus idle", 32'(n_req), 32'd0);
    end

    host_cycle("R2 after abort", 10'h2C4, 1'b0, 1'b1, 1'b1, '0, 0, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule